// File: doc/BRIEF.md
# Dual-Counter Pixel Photon Counter

This block is the digital counting core of one pixel in a photon-counting imager. It holds two 12-bit counters that count rising edges of discriminator hit pulses while the shutter is high. The same counters are read out serially over the column on a shift strobe. A two-bit depth setting limits each counter to 1, 4 or 12 bits. In sequential mode the deepest setting instead joins the two counters into one 24-bit counter.

The readout discipline is chosen by one configuration bit. In sequential mode each counter counts its own discriminator input during the shutter. The pixel is then read after the shutter closes. Shift strobes are refused while the shutter is open, so the pixel is dead while it is read. In continuous mode only the first discriminator counts, always into the active counter. Each falling edge of the shutter swaps the active and idle counters. The idle counter, which holds the previous frame, can be shifted out while the next frame is being counted, so there is no dead time.

Top module: `pixel_dual_counter`

## Requirements
- R1: After reset both counters are zero and `sout` is 0.
- R2: `depth_sel` picks the counter depth: 0 gives 1 bit, 1 gives 4 bits, 2 gives 12 bits, and 3 gives a chained 24 bits (sequential mode only).
- R3: A counter that reaches its maximum (1, 15 or 4095) stays there, and further hits are ignored until it is read out.
- R4: A hit is counted once per rising edge of the synchronized input, and only while `shutter` is high. A level held high counts once, and hits while `shutter` is low are ignored.
- R5: In sequential mode a readout of 2·w bits (w = selected width) gives the `hit_b` counter MSB first, then the `hit_a` counter MSB first. Shift strobes while `shutter` is high are ignored.
- R6: Shifting fills each counter with zeros from its LSB, so a complete readout leaves the counter cleared for the next frame.
- R7: With depth 3 in sequential mode the two counters form one 24-bit counter driven by `hit_a` only, with carry across the 12-bit boundary, read as 24 bits MSB first. `hit_b` is ignored.
- R8: In continuous mode only `hit_a` counts, into the active counter. Each falling edge of `shutter` swaps the roles, and `sout` shows the idle counter, which can be shifted out (w bits, MSB first) while the active one counts.
- R9: In continuous mode, depth 3 behaves as 12-bit (saturating at 4095).
- R10: In sequential mode with depths 0–2, `hit_a` and `hit_b` drive separate counters independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_a | input | 1 | First discriminator output (asynchronous) |
| hit_b | input | 1 | Second discriminator output (asynchronous) |
| shutter | input | 1 | Counting window, high to count |
| depth_sel | input | 2 | Counter depth: 0=1b, 1=4b, 2=12b, 3=24b chained |
| continuous | input | 1 | 1 = ping-pong continuous mode, 0 = sequential |
| shift_pulse | input | 1 | One-cycle strobe shifting readout by one bit |
| sout | output | 1 | Serial readout bit, MSB first |

## Verification
A hit that rises before clock edge n is counted at edge n+2, after two synchronizer stages. The bench therefore keeps each hit high and low for two cycles, and waits at least two more cycles before it closes the shutter or starts a readout. `sout` is a direct function of the counter registers, so the bit after a shift is valid just after the edge that takes the strobe. The bench samples `sout` on the falling edge before each strobe. The role swap in continuous mode happens at the first edge that sees the shutter low. Reads of the previous frame therefore start at least two cycles after the shutter falls.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    localparam int CNT_W = 12;
    localparam int IDX_W = $clog2(CNT_W);
    localparam int N_IN  = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        DEPTH_1  = 2'd0,
        DEPTH_4  = 2'd1,
        DEPTH_12 = 2'd2,
        DEPTH_24 = 2'd3
    } depth_e;

    typedef struct packed {
        logic cont;   // ping-pong readout
        logic chain;  // two counters joined
        idx_t msb;    // index of top bit per counter
        cnt_t limit;  // saturation value per counter
    } mode_t;

    function automatic int width_of(depth_e d);
        case (d)
            DEPTH_1: return 1;
            DEPTH_4: return 4;
            default: return CNT_W;
        endcase
    endfunction

    function automatic cnt_t limit_of(int w);
        cnt_t l;
        for (int i = 0; i < CNT_W; i++) l[i] = (i < w);
        return l;
    endfunction

endpackage

// File: rtl/pxc_hit_sync.sv
module pxc_hit_sync
    import pxc_pkg::*;
#(
    parameter int N      = N_IN,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hit_in,
    output logic [N-1:0] hit_rise
);

    for (genvar g = 0; g < N; g++) begin : g_sync
        logic [STAGES:0] pipe_q;

        always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= {pipe_q[STAGES-1:0], hit_in[g]};
        end

        assign hit_rise[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            hit_rise[g] |=> !hit_rise[g]); // R4
    end

endmodule

// File: rtl/pxc_mode_ctrl.sv
module pxc_mode_ctrl
    import pxc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shutter,
    input  logic       cfg_cont,
    input  depth_e     cfg_depth,
    input  logic [1:0] hit_rise,
    input  logic       shift_pulse,
    output mode_t      mode,
    output logic [1:0] inc,
    output logic       shift_chain,
    output logic [1:0] shift_one,
    output logic       read_sel
);

    logic   shutter_q;
    logic   active_q;
    depth_e depth_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            shutter_q <= 1'b0;
            active_q  <= 1'b0;
        end else begin
            shutter_q <= shutter;
            if (cfg_cont && shutter_q && !shutter)
                active_q <= ~active_q;
        end
    end

    always_comb begin
        depth_eff  = (cfg_cont && cfg_depth == DEPTH_24) ? DEPTH_12 : cfg_depth;
        mode.cont  = cfg_cont;
        mode.chain = !cfg_cont && (cfg_depth == DEPTH_24);
        mode.limit = limit_of(width_of(depth_eff));
        mode.msb   = idx_t'(width_of(depth_eff) - 1);
    end

    always_comb begin
        inc         = 2'b00;
        shift_chain = 1'b0;
        shift_one   = 2'b00;
        read_sel    = ~active_q;
        if (cfg_cont) begin
            if (shutter && hit_rise[0])
                inc = active_q ? 2'b10 : 2'b01;
            if (shift_pulse)
                shift_one = active_q ? 2'b01 : 2'b10;
        end else begin
            if (shutter)
                inc = mode.chain ? {1'b0, hit_rise[0]} : hit_rise;
            shift_chain = shift_pulse && !shutter;
        end
    end

    AST_SWAP_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (cfg_cont && $fell(shutter)) |=> (active_q != $past(active_q))); // R8

    AST_ROLE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (shutter && $past(shutter)) |=> $stable(active_q)); // R8

    AST_DEAD_TIME: assert property (@(posedge clk) disable iff (rst)
        !(shift_chain && (inc != 2'b00))); // R5

    AST_IDLE_NOT_COUNTED: assert property (@(posedge clk) disable iff (rst)
        !(cfg_cont && ((inc & shift_one) != 2'b00))); // R8

endmodule

// File: rtl/pxc_counter_bank.sv
module pxc_counter_bank
    import pxc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mode_t      mode,
    input  logic [1:0] inc,
    input  logic       shift_chain,
    input  logic [1:0] shift_one,
    input  logic       read_sel,
    output logic       sout
);

    cnt_t cnt_q [2];
    cnt_t cnt_d [2];
    logic [2*CNT_W-1:0] joined;

    always_comb begin
        joined   = {cnt_q[1], cnt_q[0]};
        cnt_d[0] = cnt_q[0];
        cnt_d[1] = cnt_q[1];
        if (mode.chain) begin
            if (inc[0] && !(&joined))
                {cnt_d[1], cnt_d[0]} = joined + 1'b1;
        end else begin
            for (int i = 0; i < 2; i++)
                if (inc[i] && cnt_q[i] != mode.limit)
                    cnt_d[i] = cnt_q[i] + 1'b1;
        end
        if (shift_chain) begin
            cnt_d[1] = ((cnt_q[1] << 1) | cnt_t'(cnt_q[0][mode.msb])) & mode.limit;
            cnt_d[0] = (cnt_q[0] << 1) & mode.limit;
        end
        for (int i = 0; i < 2; i++)
            if (shift_one[i])
                cnt_d[i] = (cnt_q[i] << 1) & mode.limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q[0] <= '0;
            cnt_q[1] <= '0;
        end else begin
            cnt_q[0] <= cnt_d[0];
            cnt_q[1] <= cnt_d[1];
        end
    end

    assign sout = mode.cont ? cnt_q[read_sel][mode.msb] : cnt_q[1][mode.msb];

    for (genvar g = 0; g < 2; g++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            (!mode.chain && inc[g] && !shift_chain && !shift_one[g]
             && cnt_q[g] == mode.limit) |=> (cnt_q[g] == $past(cnt_q[g]))); // R3

        AST_SHIFT_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
            shift_one[g] |=> (cnt_q[g][0] == 1'b0)); // R6
    end

    AST_CHAIN_SAT: assert property (@(posedge clk) disable iff (rst)
        (mode.chain && inc[0] && !shift_chain && (&joined)) |=> (&joined)); // R7

endmodule

// File: rtl/pixel_dual_counter.sv
module pixel_dual_counter
    import pxc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic       shutter,
    input  logic [1:0] depth_sel,
    input  logic       continuous,
    input  logic       shift_pulse,
    output logic       sout
);

    logic [1:0] hit_rise;
    mode_t      mode;
    logic [1:0] inc;
    logic       shift_chain;
    logic [1:0] shift_one;
    logic       read_sel;

    pxc_hit_sync #(.N(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .hit_in   ({hit_b, hit_a}),
        .hit_rise (hit_rise)
    );

    pxc_mode_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .shutter     (shutter),
        .cfg_cont    (continuous),
        .cfg_depth   (depth_e'(depth_sel)),
        .hit_rise    (hit_rise),
        .shift_pulse (shift_pulse),
        .mode        (mode),
        .inc         (inc),
        .shift_chain (shift_chain),
        .shift_one   (shift_one),
        .read_sel    (read_sel)
    );

    pxc_counter_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .inc         (inc),
        .shift_chain (shift_chain),
        .shift_one   (shift_one),
        .read_sel    (read_sel),
        .sout        (sout)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !sout); // R1

endmodule

// File: tb/pixel_dual_counter_tb.sv
module pixel_dual_counter_tb_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       hit_a, hit_b, shutter, continuous, shift_pulse;
    logic [1:0] depth_sel;
    logic       sout;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pixel_dual_counter dut_i (
        .clk(clk), .rst(rst), .hit_a(hit_a), .hit_b(hit_b),
        .shutter(shutter), .depth_sel(depth_sel), .continuous(continuous),
        .shift_pulse(shift_pulse), .sout(sout)
    );

    function automatic int w_of(int d);
        return (d == 0) ? 1 : (d == 1) ? 4 : 12;
    endfunction

    function automatic longint sat(longint v, longint lim);
        return (v > lim) ? lim : v;
    endfunction

    task automatic check(input string tag, input longint got, input longint exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hits(input int slots, input bit use_b, output int na, output int nb);
        na = 0; nb = 0;
        for (int i = 0; i < slots; i++) begin
            bit a = 1'($urandom_range(0, 1));
            bit b = use_b ? 1'($urandom_range(0, 1)) : 1'b0;
            na += a; nb += b;
            hit_a = a; hit_b = b;
            idle(2);
            hit_a = 0; hit_b = 0;
            idle(2);
        end
    endtask

    task automatic burst_a(input int n);
        for (int i = 0; i < n; i++) begin
            hit_a = 1; idle(2);
            hit_a = 0; idle(2);
        end
    endtask

    task automatic read_bits(input int n, output longint val);
        val = 0;
        for (int i = 0; i < n; i++) begin
            val = (val << 1) | longint'(sout);
            shift_pulse = 1;
            @(negedge clk);
            shift_pulse = 0;
        end
    endtask

    task automatic do_reset();
        rst = 1; hit_a = 0; hit_b = 0; shutter = 0; continuous = 0;
        shift_pulse = 0; depth_sel = 2'd0;
        idle(3);
        rst = 0;
        idle(1);
    endtask

    task automatic t_reset();
        longint v;
        do_reset();
        check("R1 sout after reset", sout, 0);
        depth_sel = 2'd3;
        read_bits(24, v);
        check("R1 counters zero", v, 0);
    endtask

    task automatic t_seq(input int d, input int slots);
        int na, nb, w;
        longint v, lim;
        w = w_of(d); lim = (longint'(1) << w) - 1;
        continuous = 0; depth_sel = 2'(d);
        shutter = 1; idle(2);
        hits(slots, 1'b1, na, nb);
        idle(2); shutter = 0; idle(2);
        read_bits(2 * w, v);
        check($sformatf("R5 R10 R2 seq depth %0d", d), v,
              (sat(nb, lim) << w) | sat(na, lim));
        read_bits(2 * w, v);
        check($sformatf("R6 cleared depth %0d", d), v, 0);
    endtask

    task automatic t_sat();
        longint v;
        continuous = 0; depth_sel = 2'd1;
        shutter = 1; idle(2);
        burst_a(40);
        idle(2); shutter = 0; idle(2);
        read_bits(8, v);
        check("R3 4-bit saturation", v, 15);
        depth_sel = 2'd0;
        shutter = 1; idle(2);
        burst_a(3);
        idle(2); shutter = 0; idle(2);
        read_bits(2, v);
        check("R3 1-bit saturation", v, 1);
    endtask

    task automatic t_gate();
        longint v;
        continuous = 0; depth_sel = 2'd2;
        burst_a(5);
        idle(2);
        shutter = 1; idle(2);
        hit_a = 1; idle(10); hit_a = 0; idle(3);
        shutter = 0; idle(2);
        read_bits(24, v);
        check("R4 gated and edge counted", v, 1);
    endtask

    task automatic t_dead();
        longint v;
        continuous = 0; depth_sel = 2'd2;
        shutter = 1; idle(2);
        burst_a(5);
        hit_b = 1; idle(2); hit_b = 0; idle(2);
        idle(2);
        for (int i = 0; i < 8; i++) begin
            shift_pulse = 1; @(negedge clk); shift_pulse = 0; @(negedge clk);
        end
        shutter = 0; idle(2);
        read_bits(24, v);
        check("R5 shifts ignored while open", v, (longint'(1) << 12) | 5);
    endtask

    task automatic t_chain();
        longint v;
        continuous = 0; depth_sel = 2'd3;
        shutter = 1; idle(2);
        burst_a(4100);
        hit_b = 1; idle(2); hit_b = 0; idle(2);
        idle(2); shutter = 0; idle(2);
        read_bits(24, v);
        check("R7 chained 24-bit carry", v, 4100);
    endtask

    task automatic t_cont();
        int na1, nb1, na2, nb2, na3, nb3;
        longint v1, v2, v3;
        continuous = 1; depth_sel = 2'd1;
        shutter = 1; idle(2);
        hits(10, 1'b1, na1, nb1);
        idle(2); shutter = 0; idle(2);
        shutter = 1; idle(2);
        fork
            read_bits(4, v1);
            hits(8, 1'b1, na2, nb2);
        join
        check("R8 previous frame read during count", v1, sat(na1, 15));
        idle(2); shutter = 0; idle(2);
        read_bits(4, v2);
        check("R8 second frame hit_a only", v2, sat(na2, 15));
        shutter = 1; idle(2);
        hits(6, 1'b1, na3, nb3);
        idle(2); shutter = 0; idle(2);
        read_bits(4, v3);
        check("R6 cleared counter reused", v3, sat(na3, 15));
    endtask

    task automatic t_cont24();
        longint v;
        continuous = 1; depth_sel = 2'd3;
        shutter = 1; idle(2);
        burst_a(4100);
        idle(2); shutter = 0; idle(2);
        read_bits(12, v);
        check("R9 continuous depth 3 is 12-bit", v, 4095);
        check("R9 sout zero after full read", sout, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_seq(0, 6);
        t_seq(1, 12);
        t_seq(2, 40);
        t_sat();
        t_gate();
        t_dead();
        t_chain();
        do_reset();
        t_cont();
        t_cont24();
        summary();
    end

endmodule